// File: doc/BRIEF.md
# IDE DMA Transfer Sequencer

This block sits between a descriptor-driven DMA channel and a drive model and turns each slice of memory the channel offers into one storage request. A hard disk and an optical (ATAPI) drive are both served. For a disk, progress is counted in 512-byte sectors. For an optical drive, progress is counted in bytes of the current packet command, against 2048-byte logical blocks. The drive side arms the transfer with a start LBA and a count. The channel side offers address/length slices. Storage answers each request with a completion or an error.

A slice that arrives before the drive has armed DMA is handed back: the channel is told to park, and nothing is consumed. A later arm sets the active flag and kicks the channel, which then offers the slice again. The storage ports allow one request in flight at a time. A flush request is acknowledged only when no request is outstanding.

Top module: `ide_xfer_seq`

## Requirements
- R1: After reset, `status` is 0x00, `dma_active` is 0, and every pulse output (`req_valid`, `dma_end`, `chan_park`, `chan_kick`, `irq`) is 0.
- R2: A cycle with `arm_dma` high loads the start LBA and the count, sets `dma_active`, and pulses `chan_kick` one clock later.
- R3: The first pass after `xfer_go` consumes nothing. When the offered length is non-zero, it issues one request two clocks after `xfer_go`: `req_addr` is the offered address, `req_len` is the offered length, and `req_sector` is the current position.
- R4: In disk mode (`atapi_mode`=0), a completed request of L bytes advances the LBA by ceil(L/512) and lowers the remaining sector count by the same amount, saturating at zero. `req_sector` is the disk LBA.
- R5: In disk mode, when the remaining sector count is zero at a pass, the block sets `status` to 0x50, pulses `irq` and clears `dma_active`.
- R6: In ATAPI mode, a completed request of L bytes lowers the remaining packet bytes by L and adds L to a byte index. The 2048-byte LBA then advances by index/2048, and the index keeps index mod 2048. `req_sector` is LBA*4 + index/512.
- R7: In ATAPI mode, when the remaining packet bytes are zero or negative at a pass, the block sets `status` to 0x50, pulses `irq` and clears `dma_active`.
- R8: A pass made while `dma_active` is 0 pulses `chan_park`. It issues no request, ends no DMA and changes no count. This holds for a pass after `xfer_go` and for a pass after a completion.
- R9: A pass whose remaining channel length is zero pulses `dma_end` and issues no request. After a completed request the remaining length is always zero, so `dma_end` follows each successful completion.
- R10: `req_op` encodes 0 = read, 1 = write, 2 = trim, taken from `cmd_op`; a `cmd_op` of 3 issues a read. ATAPI mode always reads. `req_to_dev` is 1 for write and trim.
- R11: A response with `rsp_err` set sets `status` to 0x41, pulses `irq` and `dma_end`, and clears `dma_active`, all one clock after the response.
- R12: At most one request is outstanding. `xfer_go` is ignored while a request is pending. `flush_done` follows `flush_req` only while no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| atapi_mode | input | 1 | 1 selects optical byte accounting, 0 disk sectors |
| cmd_op | input | 2 | Disk command: 0 read, 1 write, 2 trim |
| arm_dma | input | 1 | Drive starts DMA; loads position and count |
| arm_lba | input | LBA_W | Start LBA (512 B disk, 2048 B optical) |
| arm_count | input | CNT_W | Disk sectors or optical packet bytes |
| chan_kick | output | 1 | Pulse: channel should restart |
| xfer_go | input | 1 | Channel offers a slice |
| go_addr | input | ADDR_W | Slice memory address |
| go_len | input | LEN_W | Slice length in bytes |
| chan_park | output | 1 | Pulse: slice not consumed, channel stops processing |
| dma_end | output | 1 | Pulse: end of DMA for the channel |
| req_valid | output | 1 | Pulse: storage request issued |
| req_op | output | 2 | Request kind (R10 encoding) |
| req_to_dev | output | 1 | Data flows toward the device |
| req_addr | output | ADDR_W | Request memory address |
| req_len | output | LEN_W | Request length in bytes |
| req_sector | output | LBA_W+2 | Starting media position in 512-byte units |
| rsp_valid | input | 1 | Storage completion |
| rsp_err | input | 1 | Completion reports an error |
| flush_req | input | 1 | Flush asked |
| flush_done | output | 1 | Flush may proceed (nothing pending) |
| status | output | 8 | Drive status byte |
| irq | output | 1 | Pulse: drive interrupt |
| dma_active | output | 1 | Drive has armed DMA |

## Verification
Every result is registered. `chan_kick` is due one clock after the arm cycle. The park, end or request outcome of an offered slice is due two clocks after `xfer_go`: one edge enters the evaluation pass, the next registers the result. A successful completion is due two clocks after `rsp_valid`, and an error completion one clock after it. `flush_done` is combinational and is read in the same cycle. Each bench task drives its input just after an edge, counts that exact number of edges, and samples one time step later, so every check reads a pulse in the single cycle it is high.

// File: rtl/ide_seq_pkg.sv
package ide_seq_pkg;
  localparam int DISK_SHIFT = 9;   // 512-byte sectors
  localparam int CD_SHIFT   = 11;  // 2048-byte optical blocks

  localparam logic [7:0] ST_OK  = 8'h50;  // ready + seek complete
  localparam logic [7:0] ST_ERR = 8'h41;  // ready + error

  typedef enum logic [1:0] {OP_READ = 2'd0, OP_WRITE = 2'd1, OP_TRIM = 2'd2} xfer_op_e;
  typedef enum logic [1:0] {S_IDLE, S_EVAL, S_WAIT} seq_state_e;

  // whole 512-byte sectors covered by a byte count (partial sector counts)
  function automatic logic [31:0] disk_span(input logic [31:0] nbytes);
    return (nbytes + 32'd511) >> DISK_SHIFT;
  endfunction

  // optical position expressed in 512-byte media units
  function automatic logic [33:0] cd_media_unit(input logic [31:0] blk,
                                                input logic [CD_SHIFT-1:0] ofs);
    return {blk, 2'b00} + 34'(ofs >> DISK_SHIFT);
  endfunction

  function automatic xfer_op_e pick_op(input logic cd, input logic [1:0] code);
    if (cd) return OP_READ;
    case (code)
      2'd1:    return OP_WRITE;
      2'd2:    return OP_TRIM;
      default: return OP_READ;
    endcase
  endfunction
endpackage

// File: rtl/ide_seq_disk_acct.sv
module ide_seq_disk_acct
  import ide_seq_pkg::*;
#(
  parameter int LBA_W = 32,
  parameter int CNT_W = 24,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LBA_W-1:0] load_lba,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic             apply,
  input  logic [LEN_W-1:0] chunk,
  output logic [LBA_W-1:0] nxt_lba,
  output logic             done_nxt
);
  logic [LBA_W-1:0] lba_q;
  logic [CNT_W-1:0] cnt_q, nxt_cnt;
  logic [31:0]      span;

  always_comb begin
    span     = disk_span(32'(chunk));
    nxt_lba  = lba_q + LBA_W'(span);
    nxt_cnt  = (32'(cnt_q) > span) ? cnt_q - CNT_W'(span) : '0;
    done_nxt = (nxt_cnt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lba_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      lba_q <= load_lba;
      cnt_q <= load_cnt;
    end else if (apply) begin
      lba_q <= nxt_lba;
      cnt_q <= nxt_cnt;
    end
  end

  // R3
  zero_chunk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && !load && chunk == '0) |=> $stable(lba_q));
  // R4
  lba_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && !load && chunk != '0) |=> (lba_q != $past(lba_q)));
endmodule

// File: rtl/ide_seq_cd_acct.sv
module ide_seq_cd_acct
  import ide_seq_pkg::*;
#(
  parameter int LBA_W = 32,
  parameter int CNT_W = 24,
  parameter int LEN_W = 16,
  localparam int REM_W = CNT_W + 2,
  localparam int SEC_W = LBA_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LBA_W-1:0] load_lba,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic             apply,
  input  logic [LEN_W-1:0] chunk,
  output logic [SEC_W-1:0] nxt_unit,
  output logic             done_nxt
);
  logic [LBA_W-1:0]        lba_q, nxt_lba;
  logic [CD_SHIFT-1:0]     idx_q, nxt_idx;
  logic signed [REM_W-1:0] rem_q, nxt_rem;
  logic [31:0]             idx_sum;

  always_comb begin
    idx_sum  = 32'(idx_q) + 32'(chunk);
    nxt_lba  = lba_q + LBA_W'(idx_sum >> CD_SHIFT);
    nxt_idx  = idx_sum[CD_SHIFT-1:0];
    nxt_rem  = rem_q - $signed(REM_W'(chunk));
    done_nxt = nxt_rem[REM_W-1] || (nxt_rem == '0);
    nxt_unit = SEC_W'(cd_media_unit(32'(nxt_lba), nxt_idx));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lba_q <= '0;
      idx_q <= '0;
      rem_q <= '0;
    end else if (load) begin
      lba_q <= load_lba;
      idx_q <= '0;
      rem_q <= $signed(REM_W'(load_cnt));
    end else if (apply) begin
      lba_q <= nxt_lba;
      idx_q <= nxt_idx;
      rem_q <= nxt_rem;
    end
  end

  // R6
  rem_never_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && !load) |=> (rem_q <= $past(rem_q)));
endmodule

// File: rtl/ide_seq_ctrl.sv
module ide_seq_ctrl
  import ide_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int SEC_W  = 34
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              atapi_mode,
  input  logic [1:0]        cmd_op,
  input  logic              arm_dma,
  input  logic              xfer_go,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [LEN_W-1:0]  go_len,
  input  logic              rsp_valid,
  input  logic              rsp_err,
  input  logic              flush_req,
  input  logic              done_nxt,
  input  logic [SEC_W-1:0]  sector_nxt,
  output logic              apply,
  output logic [LEN_W-1:0]  chunk,
  output logic              chan_kick,
  output logic              chan_park,
  output logic              dma_end,
  output logic              req_valid,
  output logic [1:0]        req_op,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len,
  output logic [SEC_W-1:0]  req_sector,
  output logic              irq,
  output logic [7:0]        status,
  output logic              active,
  output logic              pending,
  output logic              flush_done
);
  seq_state_e        state;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;

  assign apply      = (state == S_EVAL) && active;
  assign pending    = (state == S_WAIT);
  assign flush_done = flush_req && !pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; addr_q <= '0; len_q <= '0; chunk <= '0;
      chan_kick <= 1'b0; chan_park <= 1'b0; dma_end <= 1'b0; req_valid <= 1'b0;
      req_op <= OP_READ; req_addr <= '0; req_len <= '0; req_sector <= '0;
      irq <= 1'b0; status <= 8'h00; active <= 1'b0;
    end else begin
      chan_kick <= 1'b0; chan_park <= 1'b0; dma_end <= 1'b0;
      req_valid <= 1'b0; irq <= 1'b0;
      case (state)
        S_IDLE: if (xfer_go) begin
          addr_q <= go_addr;
          len_q  <= go_len;
          chunk  <= '0;
          state  <= S_EVAL;
        end
        S_EVAL: begin
          if (!active) begin
            chan_park <= 1'b1;
            state     <= S_IDLE;
          end else begin
            if (done_nxt) begin
              status <= ST_OK;
              irq    <= 1'b1;
              active <= 1'b0;
            end
            if (len_q == '0) begin
              dma_end <= 1'b1;
              state   <= S_IDLE;
            end else begin
              req_valid  <= 1'b1;
              req_addr   <= addr_q;
              req_len    <= len_q;
              req_sector <= sector_nxt;
              req_op     <= pick_op(atapi_mode, cmd_op);
              chunk      <= len_q;
              addr_q     <= addr_q + ADDR_W'(len_q);
              len_q      <= '0;
              state      <= S_WAIT;
            end
          end
        end
        S_WAIT: if (rsp_valid) begin
          if (rsp_err) begin
            status  <= ST_ERR;
            irq     <= 1'b1;
            dma_end <= 1'b1;
            active  <= 1'b0;
            chunk   <= '0;
            state   <= S_IDLE;
          end else begin
            state <= S_EVAL;
          end
        end
        default: state <= S_IDLE;
      endcase
      if (arm_dma) begin
        active    <= 1'b1;
        chan_kick <= 1'b1;
      end
    end
  end

  // R12
  single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !rsp_valid) |=> !req_valid);
  // R12
  flush_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |-> !pending);
  // R9
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_valid, dma_end, chan_park}));
  // R5
  irq_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status == ST_OK || status == ST_ERR));
  // R11
  err_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && rsp_valid && rsp_err && !arm_dma) |=> (dma_end && status == ST_ERR && !active));
endmodule

// File: rtl/ide_xfer_seq.sv
module ide_xfer_seq
  import ide_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int LBA_W  = 32,
  parameter int CNT_W  = 24,
  localparam int SEC_W = LBA_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              atapi_mode,
  input  logic [1:0]        cmd_op,
  input  logic              arm_dma,
  input  logic [LBA_W-1:0]  arm_lba,
  input  logic [CNT_W-1:0]  arm_count,
  output logic              chan_kick,
  input  logic              xfer_go,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [LEN_W-1:0]  go_len,
  output logic              chan_park,
  output logic              dma_end,
  output logic              req_valid,
  output logic [1:0]        req_op,
  output logic              req_to_dev,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len,
  output logic [SEC_W-1:0]  req_sector,
  input  logic              rsp_valid,
  input  logic              rsp_err,
  input  logic              flush_req,
  output logic              flush_done,
  output logic [7:0]        status,
  output logic              irq,
  output logic              dma_active
);
  logic             apply, pending, dk_done, cd_done, done_nxt;
  logic [LEN_W-1:0] chunk;
  logic [LBA_W-1:0] dk_lba;
  logic [SEC_W-1:0] cd_unit, sector_nxt;

  assign done_nxt   = atapi_mode ? cd_done : dk_done;
  assign sector_nxt = atapi_mode ? cd_unit : SEC_W'(dk_lba);
  assign req_to_dev = (req_op != OP_READ);

  ide_seq_disk_acct #(.LBA_W(LBA_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_disk (
    .clk(clk), .rst_n(rst_n), .load(arm_dma), .load_lba(arm_lba), .load_cnt(arm_count),
    .apply(apply), .chunk(chunk), .nxt_lba(dk_lba), .done_nxt(dk_done));

  ide_seq_cd_acct #(.LBA_W(LBA_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_cd (
    .clk(clk), .rst_n(rst_n), .load(arm_dma), .load_lba(arm_lba), .load_cnt(arm_count),
    .apply(apply), .chunk(chunk), .nxt_unit(cd_unit), .done_nxt(cd_done));

  ide_seq_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SEC_W(SEC_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .atapi_mode(atapi_mode), .cmd_op(cmd_op), .arm_dma(arm_dma),
    .xfer_go(xfer_go), .go_addr(go_addr), .go_len(go_len), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .flush_req(flush_req), .done_nxt(done_nxt), .sector_nxt(sector_nxt),
    .apply(apply), .chunk(chunk), .chan_kick(chan_kick), .chan_park(chan_park),
    .dma_end(dma_end), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_len(req_len), .req_sector(req_sector), .irq(irq), .status(status),
    .active(dma_active), .pending(pending), .flush_done(flush_done));

  // R2
  kick_after_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_dma |=> (chan_kick && dma_active));
endmodule

// File: tb/ide_xfer_seq_bench.sv
module ide_xfer_seq_bench;
  localparam int ADDR_W = 32, LEN_W = 16, LBA_W = 32, CNT_W = 24, SEC_W = LBA_W + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic atapi_mode = 1'b0, arm_dma = 1'b0, xfer_go = 1'b0;
  logic rsp_valid = 1'b0, rsp_err = 1'b0, flush_req = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [LBA_W-1:0] arm_lba = '0;
  logic [CNT_W-1:0] arm_count = '0;
  logic [ADDR_W-1:0] go_addr = '0;
  logic [LEN_W-1:0] go_len = '0;
  logic chan_kick, chan_park, dma_end, req_valid, req_to_dev, flush_done, irq, dma_active;
  logic [1:0] req_op;
  logic [ADDR_W-1:0] req_addr;
  logic [LEN_W-1:0] req_len;
  logic [SEC_W-1:0] req_sector;
  logic [7:0] status;

  ide_xfer_seq u_ide_xfer_seq (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit m_active = 0, m_cd = 0;
  longint m_lba = 0, m_cnt = 0, m_idx = 0, m_rem = 0, m_chunk = 0;
  int m_op = 0;
  longint m_status = 0;

  task automatic report_end();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      report_end();
    end
  end

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic longint sectors_of(input longint b);
    return b / 512 + ((b % 512) != 0 ? 1 : 0);
  endfunction

  function automatic longint expect_pos();
    if (m_cd) return m_lba * 4 + m_idx / 512;
    return m_lba;
  endfunction

  function automatic bit model_done();
    if (m_cd) return m_rem <= 0;
    return m_cnt == 0;
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic arm(input longint lba, input longint cnt);
    arm_lba = LBA_W'(lba); arm_count = CNT_W'(cnt); arm_dma = 1'b1;
    tick();
    arm_dma = 1'b0;
    chk("R2", "chan_kick", longint'(chan_kick), 1);
    chk("R2", "dma_active", longint'(dma_active), 1);
    m_active = 1; m_lba = lba; m_cnt = cnt; m_rem = cnt; m_idx = 0;
  endtask

  task automatic offer(input longint addr, input longint len, output bit issued);
    bit d;
    go_addr = ADDR_W'(addr); go_len = LEN_W'(len); xfer_go = 1'b1;
    tick();
    xfer_go = 1'b0;
    tick();
    issued = 0;
    if (!m_active) begin
      chk("R8", "chan_park", longint'(chan_park), 1);
      chk("R8", "req_valid", longint'(req_valid), 0);
      chk("R8", "dma_end", longint'(dma_end), 0);
    end else begin
      d = model_done();
      chk(m_cd ? "R7" : "R5", "irq on pass", longint'(irq), longint'(d));
      if (d) begin m_active = 0; m_status = 'h50; end
      if (len == 0) begin
        chk("R9", "dma_end", longint'(dma_end), 1);
        chk("R9", "req_valid", longint'(req_valid), 0);
      end else begin
        chk("R3", "req_valid", longint'(req_valid), 1);
        chk("R3", "req_addr", longint'(req_addr), addr);
        chk("R3", "req_len", longint'(req_len), len);
        chk(m_cd ? "R6" : "R4", "req_sector", longint'(req_sector), expect_pos());
        chk("R10", "req_op", longint'(req_op), m_cd ? 0 : (m_op == 3 ? 0 : m_op));
        chk("R10", "req_to_dev", longint'(req_to_dev), (!m_cd && (m_op == 1 || m_op == 2)) ? 1 : 0);
        m_chunk = len;
        issued = 1;
      end
      chk(m_cd ? "R7" : "R5", "status", longint'(status), m_status);
    end
  endtask

  task automatic answer(input bit err);
    longint s, n;
    bit d;
    rsp_valid = 1'b1; rsp_err = err;
    tick();
    rsp_valid = 1'b0; rsp_err = 1'b0;
    if (err) begin
      chk("R11", "status", longint'(status), 'h41);
      chk("R11", "irq", longint'(irq), 1);
      chk("R11", "dma_end", longint'(dma_end), 1);
      chk("R11", "dma_active", longint'(dma_active), 0);
      m_active = 0; m_status = 'h41;
      return;
    end
    tick();
    if (!m_active) begin
      chk("R8", "chan_park after completion", longint'(chan_park), 1);
      chk("R8", "dma_end", longint'(dma_end), 0);
      chk("R8", "irq", longint'(irq), 0);
      return;
    end
    if (m_cd) begin
      s = m_idx + m_chunk;
      m_lba += s / 2048; m_idx = s % 2048; m_rem -= m_chunk;
    end else begin
      n = sectors_of(m_chunk);
      m_lba += n; m_cnt = (m_cnt > n) ? m_cnt - n : 0;
    end
    d = model_done();
    chk(m_cd ? "R7" : "R5", "irq", longint'(irq), longint'(d));
    if (d) begin m_active = 0; m_status = 'h50; end
    chk("R9", "dma_end after completion", longint'(dma_end), 1);
    chk(m_cd ? "R7" : "R5", "status", longint'(status), m_status);
    chk(m_cd ? "R7" : "R5", "dma_active", longint'(dma_active), longint'(m_active));
  endtask

  task automatic set_mode(input bit cd, input int op);
    m_cd = cd; m_op = op; atapi_mode = cd; cmd_op = 2'(op);
  endtask

  initial begin
    bit iss;
    void'($urandom(32'd2024));
    repeat (3) tick();
    // R1 reset state
    chk("R1", "status", longint'(status), 0);
    chk("R1", "dma_active", longint'(dma_active), 0);
    chk("R1", "pulses", longint'({req_valid, dma_end, chan_park, chan_kick, irq}), 0);
    rst_n = 1'b1;
    tick();

    // R8 slice before arm is handed back
    set_mode(0, 0);
    offer(32'h1000, 512, iss);
    arm(100, 2);
    offer(32'h1000, 1024, iss);
    // R12 flush and second go while pending
    flush_req = 1'b1; #1;
    chk("R12", "flush_done while pending", longint'(flush_done), 0);
    xfer_go = 1'b1; tick(); xfer_go = 1'b0; tick();
    chk("R12", "no second request", longint'(req_valid), 0);
    answer(0);
    chk("R12", "flush_done when idle", longint'(flush_done), 1);
    flush_req = 1'b0;
    chk("R4", "lba after 1024 bytes", m_lba, 102);

    // R4 rounding: 513 bytes takes two sectors, then one byte takes one
    set_mode(0, 1);
    arm(40, 10);
    offer(32'h2000, 513, iss); answer(0);
    offer(32'h3000, 1, iss);
    chk("R4", "sector after 513 bytes", longint'(req_sector), 42);
    answer(0);
    // R9 zero-length offer
    set_mode(0, 2);
    offer(32'h4000, 0, iss);
    offer(32'h4000, 700, iss);  // R10 trim
    answer(0);
    // R5 run to zero
    arm(7, 1);
    offer(32'h5000, 4096, iss); answer(0);
    offer(32'h5000, 64, iss);   // parked, R8

    // R6/R7 optical accounting
    set_mode(1, 1);
    arm(5, 3000);
    offer(32'h6000, 1500, iss);
    chk("R6", "first unit", longint'(req_sector), 20);
    answer(0);
    offer(32'h7000, 1000, iss);
    chk("R6", "unit with index", longint'(req_sector), 22);
    answer(0);
    offer(32'h8000, 600, iss);
    chk("R6", "unit after wrap", longint'(req_sector), 24);
    answer(0);

    // R11 error path
    set_mode(0, 0);
    arm(9, 4);
    offer(32'h9000, 512, iss);
    answer(1);
    offer(32'h9000, 512, iss);

    // mixed random traffic
    for (int t = 0; t < 60; t++) begin
      set_mode(1'($urandom % 2), int'($urandom % 4));
      arm(longint'($urandom % (1 << 20)),
          m_cd ? longint'($urandom % 6000) : longint'($urandom % 7));
      for (int c = 0; c < 3; c++) begin
        offer(longint'($urandom),
              ($urandom % 5 == 0) ? 0 : longint'(1 + $urandom % 4096), iss);
        if (iss) answer($urandom % 10 == 0);
      end
    end
    report_end();
  end
endmodule